// File: doc/BRIEF.md
# Firmware Download Host Sequencer

This block is a bus master that pushes a firmware image into a peripheral through that peripheral's configuration register window. It reads the image one byte at a time from a local memory and packs four bytes into each 32-bit word, lowest address in the least significant byte. It switches the peripheral into download mode, then hands the words over through two data registers that take turns. Each data register has its own ready flag, so the peripheral can absorb one word while the next is being prepared.

When the image has been sent, the sequencer waits for both ready flags to clear and leaves download mode. It then polls the peripheral's result field. If the result never arrives and the field still reads "no result", the whole download starts again, up to a limit. Any other outcome ends the run with a code.

The configuration window is reached over a simple request/acknowledge port that accepts byte and dword accesses. All delays and poll limits are parameters counted in clock cycles.

Top module: `fw_loader_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timeout`, `drain_warn` are 0 and `err_code` is 2'b00. A one-cycle `start` while idle clears these flags, loads the word count as `img_len` divided by 4 (remainder dropped) and makes `busy` 1 from the next cycle.
- R2: Every attempt begins with a byte write of 0x01 to address 0xF4 (download enable), issued before any data word.
- R3: Word n is written as a dword to 0xF8 when n is even and to 0xFC when n is odd. Its bits [8k+7:8k] are the image byte at address 4n+k.
- R4: Before word n is written, 0xF5 is read until bit (n & 1) reads 0. If POLL_MAX reads all show the bit set, the run ends with `timeout`=1 and `err_code`=2'b11.
- R5: After each data-write acknowledge, SETTLE_CYC idle cycles pass. The sequencer then byte-writes 0xF5 with only bit (n & 1) set.
- R6: After the last word, 0xF5 is read until bits 1:0 are both 0. If POLL_MAX reads do not see this, `drain_warn` is set and the sequence continues.
- R7: Next, 0x00 is byte-written to 0xF4 and 0xF4 is polled. A read with bit 4 set ends the run with `done`=1, `err_code`=2'b00 and `timeout`=0.
- R8: If POLL_MAX result reads pass without bit 4 and the last read has bits 6:4 = 000, the whole attempt restarts from R2. After MAX_RETRY restarts the run ends with `timeout`=1 and `err_code`=2'b11.
- R9: If the result poll runs out and the last read has a nonzero code in bits 6:4, the run ends with `err_code`=2'b10 and no retry.
- R10: An acknowledge that carries `cfg_err` ends the run in the next cycle with `err_code`=2'b01. No further access is made.
- R11: `start` is ignored while `busy` is 1. A request holds its address, direction and data until it is acknowledged. No request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse |
| img_len | input | LEN_W | Image length in bytes |
| img_addr | output | LEN_W | Byte address into image memory |
| img_byte | input | 8 | Image byte at `img_addr`, same cycle |
| cfg_req | output | 1 | Configuration access request |
| cfg_we | output | 1 | 1 = write, 0 = read |
| cfg_dword | output | 1 | 1 = dword access, 0 = byte access |
| cfg_addr | output | 8 | Configuration register address |
| cfg_wdata | output | 32 | Write data |
| cfg_ack | input | 1 | Access complete; read data valid |
| cfg_err | input | 1 | Access failed, valid with `cfg_ack` |
| cfg_rdata | input | 8 | Read byte |
| busy | output | 1 | Sequence running |
| done | output | 1 | Download accepted |
| timeout | output | 1 | Ended on a poll or retry limit |
| drain_warn | output | 1 | Final flag drain did not complete |
| err_code | output | 2 | 00 none, 01 bus error, 10 bad result, 11 timeout |

## Verification
The assertions check on every cycle the behaviour that holds at any moment. Requests stay stable until acknowledged, dword accesses only reach the two data registers, and each flag-set write carries exactly one bit. A bus error always ends the run with code 01, and `done` never appears together with an error. The order of the whole write stream, the little-endian packing, the length of the settle gap, and the retry count can only be shown by the bench's scenarios. The same holds for each way a run can end: a stuck flag, a drain that does not finish, a bad result code, and running out of retries. For these the bench uses a peripheral model that records every access together with its cycle.

// File: rtl/fw_loader_seq.sv
module fw_loader_seq #(
  parameter int LEN_W      = 16,
  parameter int POLL_MAX   = 10000,
  parameter int SETTLE_CYC = 25000,
  parameter int MAX_RETRY  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  output logic [LEN_W-1:0] img_addr,
  input  logic [7:0]       img_byte,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic             cfg_dword,
  output logic [7:0]       cfg_addr,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_ack,
  input  logic             cfg_err,
  input  logic [7:0]       cfg_rdata,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic             drain_warn,
  output logic [1:0]       err_code
);
  localparam int WC_W = LEN_W - 2;
  localparam int PC_W = $clog2(POLL_MAX + 1);
  localparam int SC_W = $clog2(SETTLE_CYC + 1);
  localparam int RC_W = $clog2(MAX_RETRY + 1);
  localparam logic [7:0] A_CTL = 8'hF4, A_HS = 8'hF5, A_D0 = 8'hF8, A_D1 = 8'hFC;

  typedef enum logic [3:0] {
    S_IDLE, S_ENA, S_HSPOLL, S_FETCH, S_DWR, S_SETTLE, S_HSSET, S_DRAIN, S_DIS, S_RES
  } st_t;

  st_t             st;
  logic [WC_W-1:0] words, idx;
  logic [1:0]      bsel;
  logic [31:0]     word;
  logic [PC_W-1:0] pcnt;
  logic [SC_W-1:0] scnt;
  logic [RC_W-1:0] rcnt;

  wire par       = idx[0];
  wire last_poll = pcnt == PC_W'(POLL_MAX - 1);
  wire unused_ok = ^{cfg_rdata[7], cfg_rdata[3:2], img_len[1:0]};

  assign busy      = st != S_IDLE;
  assign img_addr  = {idx, bsel};
  assign cfg_req   = st inside {S_ENA, S_HSPOLL, S_DWR, S_HSSET, S_DRAIN, S_DIS, S_RES};
  assign cfg_we    = st inside {S_ENA, S_DWR, S_HSSET, S_DIS};
  assign cfg_dword = st == S_DWR;

  always_comb begin
    cfg_addr  = A_CTL;
    cfg_wdata = 32'h0;
    case (st)
      S_ENA:            cfg_wdata = 32'h1;
      S_HSPOLL, S_DRAIN: cfg_addr = A_HS;
      S_DWR: begin
        cfg_addr  = par ? A_D1 : A_D0;
        cfg_wdata = word;
      end
      S_HSSET: begin
        cfg_addr  = A_HS;
        cfg_wdata = {30'h0, par, ~par};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; words <= '0; idx <= '0; bsel <= '0; word <= '0;
      pcnt <= '0; scnt <= '0; rcnt <= '0;
      done <= 1'b0; timeout <= 1'b0; drain_warn <= 1'b0; err_code <= 2'b00;
    end else if (cfg_req && cfg_ack && cfg_err) begin
      st <= S_IDLE;
      err_code <= 2'b01;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          words <= img_len[LEN_W-1:2];
          rcnt <= '0;
          done <= 1'b0; timeout <= 1'b0; drain_warn <= 1'b0; err_code <= 2'b00;
          st <= S_ENA;
        end
        S_ENA: if (cfg_ack) begin
          idx <= '0; pcnt <= '0;
          st <= (words == '0) ? S_DRAIN : S_HSPOLL;
        end
        S_HSPOLL: if (cfg_ack) begin
          if (!cfg_rdata[par]) begin
            bsel <= '0; st <= S_FETCH;
          end else if (last_poll) begin
            timeout <= 1'b1; err_code <= 2'b11; st <= S_IDLE;
          end else pcnt <= pcnt + 1'b1;
        end
        S_FETCH: begin
          word <= {img_byte, word[31:8]};
          bsel <= bsel + 1'b1;
          if (bsel == 2'd3) st <= S_DWR;
        end
        S_DWR: if (cfg_ack) begin
          scnt <= '0; st <= S_SETTLE;
        end
        S_SETTLE: begin
          if (scnt == SC_W'(SETTLE_CYC - 1)) st <= S_HSSET;
          else scnt <= scnt + 1'b1;
        end
        S_HSSET: if (cfg_ack) begin
          pcnt <= '0;
          if (idx == words - 1'b1) st <= S_DRAIN;
          else begin
            idx <= idx + 1'b1; st <= S_HSPOLL;
          end
        end
        S_DRAIN: if (cfg_ack) begin
          if (cfg_rdata[1:0] == 2'b00) begin
            pcnt <= '0; st <= S_DIS;
          end else if (last_poll) begin
            drain_warn <= 1'b1; pcnt <= '0; st <= S_DIS;
          end else pcnt <= pcnt + 1'b1;
        end
        S_DIS: if (cfg_ack) begin
          pcnt <= '0; st <= S_RES;
        end
        S_RES: if (cfg_ack) begin
          if (cfg_rdata[4]) begin
            done <= 1'b1; st <= S_IDLE;
          end else if (last_poll) begin
            if (cfg_rdata[6:5] != 2'b00) begin
              err_code <= 2'b10; st <= S_IDLE;
            end else if (rcnt == RC_W'(MAX_RETRY)) begin
              timeout <= 1'b1; err_code <= 2'b11; st <= S_IDLE;
            end else begin
              rcnt <= rcnt + 1'b1; st <= S_ENA;
            end
          end else pcnt <= pcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fw_loader_seq_chk.sv
module fw_loader_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        timeout,
  input logic        cfg_req,
  input logic        cfg_we,
  input logic        cfg_dword,
  input logic [7:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        cfg_ack,
  input logic        cfg_err,
  input logic [1:0]  err_code
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_addr) && $stable(cfg_we) && $stable(cfg_wdata)); // R11
  AST_DWORD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_dword |-> cfg_we && (cfg_addr == 8'hF8 || cfg_addr == 8'hFC)); // R3
  AST_FLAG_SET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_we && !cfg_dword && cfg_addr == 8'hF5 |-> $countones(cfg_wdata) == 1 && cfg_wdata[31:2] == 30'h0); // R5
  AST_BUS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_ack && cfg_err |=> !busy && err_code == 2'b01); // R10
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && err_code == 2'b00 && !timeout); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cfg_req); // R11
  AST_TIMEOUT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> err_code == 2'b11); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> busy || done || err_code != 2'b00); // R11
endmodule

bind fw_loader_seq fw_loader_seq_chk u_chk (.*);

// File: tb/fw_loader_seq_test.sv
module fw_loader_seq_test;
  localparam int LEN_W = 10, POLL = 20, SETTLE = 4, RETRY = 10, HS_LAT = 3, RES_LAT = 5;

  logic clk = 0, rst_n = 0, start = 0;
  logic [LEN_W-1:0] img_len = '0, img_addr;
  logic [7:0] img_byte, cfg_addr, cfg_rdata;
  logic cfg_req, cfg_we, cfg_dword, cfg_ack, cfg_err;
  logic [31:0] cfg_wdata;
  logic busy, done, timeout, drain_warn;
  logic [1:0] err_code;

  always #2 clk = ~clk;

  fw_loader_seq #(.LEN_W(LEN_W), .POLL_MAX(POLL), .SETTLE_CYC(SETTLE), .MAX_RETRY(RETRY)) uut (
    .clk, .rst_n, .start, .img_len, .img_addr, .img_byte, .cfg_req, .cfg_we, .cfg_dword,
    .cfg_addr, .cfg_wdata, .cfg_ack, .cfg_err, .cfg_rdata, .busy, .done, .timeout,
    .drain_warn, .err_code);

  function automatic logic [7:0] img_at(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction
  assign img_byte = img_at(int'(img_addr));

  // peripheral model
  int cyc = 0, nwr = 0, attempts = 0, err_at = -1, ok_from = 1;
  logic [2:0] bad_code = 3'b000;
  logic [1:0] stuck = 2'b00;
  logic [7:0]  w_addr [128];
  logic [31:0] w_data [128];
  int          w_cyc  [128];
  logic [1:0] hs;
  int hs_tmr [2];
  int res_tmr;
  logic en;
  logic [2:0] code;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      cfg_ack <= 0; cfg_err <= 0; cfg_rdata <= 0; hs <= 0; en <= 0; code <= 0;
      hs_tmr[0] = 0; hs_tmr[1] = 0; res_tmr = 0; nwr = 0; attempts = 0;
    end else begin
      for (int b = 0; b < 2; b++)
        if (hs_tmr[b] > 0) begin
          if (hs_tmr[b] == 1 && !stuck[b]) hs[b] <= 1'b0;
          hs_tmr[b] = hs_tmr[b] - 1;
        end
      if (res_tmr > 0) begin
        if (res_tmr == 1)
          code <= (bad_code != 0) ? bad_code : (ok_from != 0 && attempts >= ok_from) ? 3'b001 : 3'b000;
        res_tmr = res_tmr - 1;
      end
      if (cfg_req && !cfg_ack) begin
        cfg_ack <= 1;
        cfg_err <= cfg_we && (nwr == err_at);
        cfg_rdata <= (cfg_addr == 8'hF4) ? {1'b0, code, 3'b000, en} :
                     (cfg_addr == 8'hF5) ? {6'b0, hs} : 8'h00;
        if (cfg_we) begin
          if (nwr < 128) begin
            w_addr[nwr] = cfg_addr; w_data[nwr] = cfg_wdata; w_cyc[nwr] = cyc;
          end
          nwr = nwr + 1;
          if (cfg_addr == 8'hF4) begin
            if (cfg_wdata[7:0] == 8'h01) begin en <= 1; code <= 0; attempts = attempts + 1; end
            else begin en <= 0; res_tmr = RES_LAT; end
          end
          if (cfg_addr == 8'hF5)
            for (int b = 0; b < 2; b++)
              if (cfg_wdata[b]) begin hs[b] <= 1'b1; hs_tmr[b] = HS_LAT; end
        end
      end else begin
        cfg_ack <= 0; cfg_err <= 0;
      end
    end
  end

  int checks = 0, fails = 0, wd = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
      $finish;
    end
  end

  task automatic prep(int e_at, int okf, logic [2:0] bad, logic [1:0] stk);
    @(negedge clk);
    err_at = e_at; ok_from = okf; bad_code = bad; stuck = stk; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic launch(int len);
    img_len = LEN_W'(len); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic int count_enables();
    int c = 0;
    for (int i = 0; i < nwr && i < 128; i++)
      if (w_addr[i] == 8'hF4 && w_data[i] == 32'h1) c++;
    return c;
  endfunction

  task automatic t_reset();
    prep(-1, 1, 3'b000, 2'b00);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 err after reset", err_code, 0);
    chk("R1 timeout after reset", timeout, 0);
    chk("R11 no request while idle", cfg_req, 0);
  endtask

  task automatic t_normal(int len);
    int nw = len / 4;
    prep(-1, 1, 3'b000, 2'b00);
    launch(len);
    chk("R1 busy after start", busy, 1);
    wait_idle();
    chk("R7 done", done, 1);
    chk("R7 err", err_code, 0);
    chk("R6 no drain warning", drain_warn, 0);
    chk("R2 write count", nwr, 2 * nw + 2);
    chk("R2 enable first addr", w_addr[0], 8'hF4);
    chk("R2 enable value", int'(w_data[0]), 1);
    for (int n = 0; n < nw; n++) begin
      logic [31:0] exp = {img_at(4*n+3), img_at(4*n+2), img_at(4*n+1), img_at(4*n)};
      chk("R3 data addr", w_addr[1+2*n], (n % 2) ? 8'hFC : 8'hF8);
      chk("R3 data little-endian", int'(w_data[1+2*n]), int'(exp));
      chk("R5 flag set addr", w_addr[2+2*n], 8'hF5);
      chk("R5 flag set value", int'(w_data[2+2*n]), 1 << (n % 2));
      chk("R5 settle gap", w_cyc[2+2*n] - w_cyc[1+2*n], SETTLE + 2);
    end
    chk("R7 disable addr", w_addr[2*nw+1], 8'hF4);
    chk("R7 disable value", int'(w_data[2*nw+1]), 0);
  endtask

  task automatic t_hs_stuck();
    prep(-1, 1, 3'b000, 2'b10);
    launch(16);
    wait_idle();
    chk("R4 timeout flag", timeout, 1);
    chk("R4 timeout code", err_code, 3);
    chk("R4 words sent before stall", nwr, 1 + 2 * 3);
    chk("R4 not done", done, 0);
  endtask

  task automatic t_drain_warn();
    prep(-1, 1, 3'b000, 2'b10);
    launch(8);
    wait_idle();
    chk("R6 drain warning", drain_warn, 1);
    chk("R6 continues to done", done, 1);
    chk("R6 no timeout", timeout, 0);
  endtask

  task automatic t_bad_result();
    prep(-1, 1, 3'b010, 2'b00);
    launch(8);
    wait_idle();
    chk("R9 error code", err_code, 2);
    chk("R9 no retry", count_enables(), 1);
    chk("R9 not done", done, 0);
  endtask

  task automatic t_retry_ok();
    prep(-1, 3, 3'b000, 2'b00);
    launch(4);
    wait_idle();
    chk("R8 done after retries", done, 1);
    chk("R8 attempts", count_enables(), 3);
  endtask

  task automatic t_retry_exhaust();
    prep(-1, 0, 3'b000, 2'b00);
    launch(4);
    wait_idle();
    chk("R8 attempts at limit", count_enables(), RETRY + 1);
    chk("R8 timeout code", err_code, 3);
    chk("R8 timeout flag", timeout, 1);
  endtask

  task automatic t_bus_err();
    prep(1, 1, 3'b000, 2'b00);
    launch(20);
    wait_idle();
    chk("R10 bus error code", err_code, 1);
    chk("R10 no further writes", nwr, 2);
    repeat (5) @(negedge clk);
    chk("R10 stays idle", busy, 0);
  endtask

  task automatic t_start_busy();
    prep(-1, 1, 3'b000, 2'b00);
    launch(20);
    repeat (10) @(negedge clk);
    launch(40);
    wait_idle();
    chk("R11 second start ignored", nwr, 2 * 5 + 2);
    chk("R11 run completes", done, 1);
  endtask

  task automatic t_clear_on_start();
    prep(-1, 1, 3'b010, 2'b00);
    launch(4);
    wait_idle();
    bad_code = 3'b000;
    launch(4);
    chk("R1 error cleared by start", err_code, 0);
    wait_idle();
    chk("R1 later run succeeds", done, 1);
  endtask

  initial begin
    t_reset();
    t_normal(20);
    t_normal(14);
    t_hs_stuck();
    t_drain_warn();
    t_bad_result();
    t_retry_ok();
    t_retry_exhaust();
    t_bus_err();
    t_start_busy();
    t_clear_on_start();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule